// File: doc/BRIEF.md
# Converter Trigger and Sample Readout Controller

This block sits on the host side of a SAR converter. A one-cycle start request in idle begins the sequence. The block raises the convert pin for a minimum pulse width and then lowers it. It waits out the conversion time, then drops chip select and clocks in bytes as an SPI master in clock mode 0. When the last byte arrives it returns a sample word per hardware channel and, when the selected output mode has one, an unsigned common-mode byte. All timing windows are set in nanoseconds and turned into clock-cycle counts, rounded up.

The selected output mode sets how many bytes are read and how they are split. The mode code is latched when a start is accepted. The block also forms the mode-register byte that configuration software writes to the converter, from the mode code and a lane setting. The differential result is always left-aligned in a 32-bit word, so its sign sits in bit 31 whatever the mode.

Top module: `cnv_readout`

## Requirements
- R1: After reset: cnv_o=0, cs_no=1, sclk_o=0, busy_o=0, done_o=0, sample_o=0, cm_o=0, cm_valid_o=0.
- R2: A start_i sampled in idle raises cnv_o from the next cycle for exactly ceil(CNV_HIGH_NS/CLK_PERIOD_NS) cycles, which is 1 by default.
- R3: After cnv_o falls, cs_no stays high and cnv_o stays low for exactly ceil(CONV_WAIT_NS/CLK_PERIOD_NS) cycles (48 by default). cs_no is low only during the byte read.
- R4: The byte count per channel depends on the latched mode: code 0 gives 3, code 1 gives 3, code 2 gives 4, code 3 gives 4, code 4 gives 4. The total count is that number times N_CHAN, and sclk_o shows 8 rising edges per byte.
- R5: SPI clock mode 0. sclk_o idles low and toggles only while cs_no is low. miso_i is sampled on the rising sclk_o edge. Bits and bytes arrive MSB first.
- R6: The differential bytes are packed left-aligned into each channel's 32-bit sample, and unused low bits are zero. Code 0: 3 bytes. Code 1: 2 bytes. Code 2: 3 bytes. Codes 3 and 4: 4 bytes.
- R7: In codes 1 and 2 the byte right after a channel's differential bytes appears on cm_o, and cm_valid_o=1. In every other code cm_o=0 and cm_valid_o=0.
- R8: done_o is high for exactly one cycle, and the new sample_o, cm_o and cm_valid_o are valid in that cycle. They hold until the next done_o.
- R9: busy_o is high from the cycle after an accepted start up to and including the done_o cycle. A start_i while busy_o is high, including in the done_o cycle, is ignored.
- R10: cfg_byte_o = {lane_i[1:0], 3'b000, mode_i[2:0]}, combinational.
- R11: Reserved codes 5, 6 and 7 read and pack exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, taken only in idle |
| mode_i | input | 3 | Output-mode code, latched on an accepted start |
| lane_i | input | 2 | Lane setting for the mode-register byte |
| miso_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Convert pin |
| cs_no | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle result strobe |
| sample_o | output | 32*N_CHAN | Left-aligned signed differential samples, channel 0 in the low word |
| cm_o | output | 8*N_CHAN | Common-mode bytes |
| cm_valid_o | output | 1 | Common-mode bytes are meaningful |
| cfg_byte_o | output | 8 | Mode-register value |

## Verification
The done_o cycle is the one place where a result strobe and a new request can meet. The bench raises start_i exactly in the cycle where done_o is seen high. In the next cycle it expects busy_o and cnv_o to be low, with no new convert pulse, and it expects the previous sample to stay on sample_o. A start in the following idle cycle must then be accepted. A second start during the conversion wait must leave the latched mode and the convert-pulse count unchanged.

// File: rtl/cnv_rd_pkg.sv
package cnv_rd_pkg;

  typedef enum logic [2:0] {
    OM_DIFF    = 3'd0,
    OM_D16_CM  = 3'd1,
    OM_D24_CM  = 3'd2,
    OM_AVG30   = 3'd3,
    OM_PATTERN = 3'd4
  } out_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CNV, ST_WAIT, ST_READ, ST_DONE
  } seq_state_e;

  function automatic logic [2:0] diff_bytes(input logic [2:0] m);
    case (m)
      3'(OM_D16_CM):               return 3'd2;
      3'(OM_AVG30), 3'(OM_PATTERN): return 3'd4;
      default:                      return 3'd3;
    endcase
  endfunction

  function automatic logic has_cm(input logic [2:0] m);
    return (m == 3'(OM_D16_CM)) || (m == 3'(OM_D24_CM));
  endfunction

endpackage

// File: rtl/cnv_rd_seq.sv
module cnv_rd_seq
  import cnv_rd_pkg::*;
#(
  parameter int CNV_CYC  = 1,
  parameter int WAIT_CYC = 48
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] mode_i,
  input  logic       last_byte_i,
  output seq_state_e state_o,
  output logic [2:0] mode_o,
  output logic       cnv_o,
  output logic       cs_no,
  output logic       busy_o,
  output logic       done_o
);
  localparam int TMAX = (CNV_CYC > WAIT_CYC) ? CNV_CYC : WAIT_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  seq_state_e     state_q;
  logic [TW-1:0]  tmr_q;
  logic [2:0]     mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      mode_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CNV;
          tmr_q   <= '0;
          mode_q  <= mode_i;
        end
        ST_CNV: if (tmr_q == TW'(CNV_CYC - 1)) begin
          state_q <= ST_WAIT;
          tmr_q   <= '0;
        end else tmr_q <= tmr_q + 1'b1;
        ST_WAIT: if (tmr_q == TW'(WAIT_CYC - 1)) begin
          state_q <= ST_READ;
          tmr_q   <= '0;
        end else tmr_q <= tmr_q + 1'b1;
        ST_READ: if (last_byte_i) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign mode_o  = mode_q;
  assign cnv_o   = (state_q == ST_CNV);
  assign cs_no   = (state_q != ST_READ);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_DONE);

  // pulse and gap length monitors
  logic [15:0] hi_len_q, gap_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_len_q  <= '0;
      gap_len_q <= '0;
    end else begin
      hi_len_q  <= cnv_o ? hi_len_q + 1'b1 : '0;
      gap_len_q <= (busy_o && !cnv_o && cs_no) ? gap_len_q + 1'b1 : '0;
    end
  end

  AST_CNV_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cnv_o) |-> hi_len_q == 16'(CNV_CYC)); // R2
  AST_WAIT_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> gap_len_q == 16'(WAIT_CYC)); // R3
  AST_START_IDLE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_o) |-> $past(!busy_o && start_i)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

endmodule

// File: rtl/cnv_rd_spi_rx.sv
module cnv_rd_spi_rx #(
  parameter int SCLK_HALF = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic [7:0] byte_o,
  output logic       byte_vld_o
);
  localparam int PW = $clog2(SCLK_HALF + 1);

  logic [PW-1:0] ph_q;
  logic [2:0]    bit_q;
  logic          sclk_q, vld_q;
  logic [7:0]    sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0; bit_q <= '0; sclk_q <= 1'b0; vld_q <= 1'b0; sh_q <= '0;
    end else if (!en_i) begin
      ph_q <= '0; bit_q <= '0; sclk_q <= 1'b0; vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (ph_q == PW'(SCLK_HALF - 1)) begin
        ph_q   <= '0;
        sclk_q <= ~sclk_q;
        if (!sclk_q) sh_q <= {sh_q[6:0], miso_i};
        else if (bit_q == 3'd7) begin
          bit_q <= '0;
          vld_q <= 1'b1;
        end else bit_q <= bit_q + 1'b1;
      end else ph_q <= ph_q + 1'b1;
    end
  end

  assign sclk_o     = sclk_q;
  assign byte_o     = sh_q;
  assign byte_vld_o = vld_q;

  AST_VLD_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> !sclk_o); // R5

endmodule

// File: rtl/cnv_rd_assemble.sv
module cnv_rd_assemble
  import cnv_rd_pkg::*;
#(
  parameter int N_CHAN = 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rd_i,
  input  logic [2:0]                  mode_i,
  input  logic [7:0]                  byte_i,
  input  logic                        byte_vld_i,
  output logic                        last_o,
  output logic [N_CHAN-1:0][31:0]     sample_o,
  output logic [N_CHAN-1:0][7:0]      cm_o,
  output logic                        cm_vld_o
);
  localparam int MAXB = 4 * N_CHAN;
  localparam int IW   = $clog2(MAXB + 1);

  logic [7:0]        byte_q [MAXB];
  logic [7:0]        byte_n [MAXB];
  logic [IW-1:0]     idx_q, nbytes;
  logic [2:0]        db;
  logic              cm_en;
  int                cb;
  logic [N_CHAN-1:0][31:0] smp_n;
  logic [N_CHAN-1:0][7:0]  cm_n;

  always_comb begin
    db     = diff_bytes(mode_i);
    cm_en  = has_cm(mode_i);
    cb     = int'(db) + int'(cm_en);
    nbytes = IW'(cb * N_CHAN);
  end

  assign last_o = byte_vld_i && (idx_q == nbytes - 1'b1);

  always_comb begin
    for (int i = 0; i < MAXB; i++) begin
      byte_n[i] = byte_q[i];
      if (byte_vld_i && IW'(i) == idx_q) byte_n[i] = byte_i;
    end
    for (int c = 0; c < N_CHAN; c++) begin
      smp_n[c] = '0;
      cm_n[c]  = '0;
      for (int k = 0; k < 4; k++) begin
        if (k < int'(db) && (c * cb + k) < MAXB)
          smp_n[c][31-8*k -: 8] = byte_n[c * cb + k];
      end
      if (cm_en && (c * cb + int'(db)) < MAXB) cm_n[c] = byte_n[c * cb + int'(db)];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      sample_o <= '0;
      cm_o     <= '0;
      cm_vld_o <= 1'b0;
      for (int i = 0; i < MAXB; i++) byte_q[i] <= '0;
    end else begin
      if (!rd_i) idx_q <= '0;
      else if (byte_vld_i) idx_q <= idx_q + 1'b1;
      for (int i = 0; i < MAXB; i++) byte_q[i] <= byte_n[i];
      if (last_o) begin
        sample_o <= smp_n;
        cm_o     <= cm_n;
        cm_vld_o <= cm_en;
      end
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i |-> idx_q < nbytes); // R4
  AST_CM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cm_vld_o |-> cm_o == '0); // R7

endmodule

// File: rtl/cnv_readout.sv
module cnv_readout
  import cnv_rd_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int CNV_HIGH_NS   = 10,
  parameter int CONV_WAIT_NS  = 480,
  parameter int SCLK_HALF     = 2,
  parameter int N_CHAN        = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [2:0]            mode_i,
  input  logic [1:0]            lane_i,
  input  logic                  miso_i,
  output logic                  cnv_o,
  output logic                  cs_no,
  output logic                  sclk_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [N_CHAN*32-1:0]  sample_o,
  output logic [N_CHAN*8-1:0]   cm_o,
  output logic                  cm_valid_o,
  output logic [7:0]            cfg_byte_o
);
  localparam int CNV_RAW  = (CNV_HIGH_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int WAIT_RAW = (CONV_WAIT_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int CNV_CYC  = (CNV_RAW < 1) ? 1 : CNV_RAW;
  localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;

  seq_state_e state;
  logic [2:0] mode_q;
  logic       last_byte, byte_vld;
  logic [7:0] rx_byte;
  logic [N_CHAN-1:0][31:0] smp;
  logic [N_CHAN-1:0][7:0]  cmb;

  cnv_rd_seq #(.CNV_CYC(CNV_CYC), .WAIT_CYC(WAIT_CYC)) i_seq (
    .clk_i, .rst_ni, .start_i, .mode_i,
    .last_byte_i(last_byte), .state_o(state), .mode_o(mode_q),
    .cnv_o, .cs_no, .busy_o, .done_o
  );

  cnv_rd_spi_rx #(.SCLK_HALF(SCLK_HALF)) i_spi (
    .clk_i, .rst_ni, .en_i(state == ST_READ), .miso_i,
    .sclk_o, .byte_o(rx_byte), .byte_vld_o(byte_vld)
  );

  cnv_rd_assemble #(.N_CHAN(N_CHAN)) i_asm (
    .clk_i, .rst_ni, .rd_i(state == ST_READ), .mode_i(mode_q),
    .byte_i(rx_byte), .byte_vld_i(byte_vld), .last_o(last_byte),
    .sample_o(smp), .cm_o(cmb), .cm_vld_o(cm_valid_o)
  );

  assign sample_o   = smp;
  assign cm_o       = cmb;
  assign cfg_byte_o = {lane_i, 3'b000, mode_i};

  AST_SCLK_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no); // R5
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(sample_o)); // R8

endmodule

// File: tb/test_cnv_readout.sv
`timescale 1ns/1ps
module test_cnv_readout;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso;
  logic [2:0] mode = '0;
  logic [1:0] lane = '0;
  logic cnv, cs_n, sclk, busy, done, cm_valid;
  logic [31:0] sample;
  logic [7:0] cm, cfg;
  int n_chk = 0, n_err = 0, n_rise = 0, n_cnv = 0, slv_bit = 0;
  logic [31:0] slv_word = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  cnv_readout i_cnv_readout (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .lane_i(lane),
    .miso_i(miso), .cnv_o(cnv), .cs_no(cs_n), .sclk_o(sclk), .busy_o(busy),
    .done_o(done), .sample_o(sample), .cm_o(cm), .cm_valid_o(cm_valid),
    .cfg_byte_o(cfg)
  );

  // converter model: next bit after each falling sclk, restart on cs high
  always @(negedge sclk or posedge cs_n) begin
    if (cs_n) slv_bit <= 0;
    else slv_bit <= slv_bit + 1;
  end
  assign miso = (slv_bit < 32) ? slv_word[31 - slv_bit] : 1'b0;

  always @(posedge sclk) n_rise++;
  always @(posedge cnv) n_cnv++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int dbytes(input int m);
    return (m == 1) ? 2 : ((m == 3 || m == 4) ? 4 : 3);
  endfunction
  function automatic bit hcm(input int m);
    return (m == 1 || m == 2);
  endfunction

  task automatic conv(input int m, input logic [31:0] w);
    int hi = 0, gap = 0, to = 0, r0, db, nb;
    logic [63:0] msk;
    string rq;
    db = dbytes(m); nb = db + int'(hcm(m));
    rq = (m > 4) ? "R11" : "R6";
    mode = 3'(m); slv_word = w; start = 1'b1;
    r0 = n_rise;
    @(negedge clk); start = 1'b0;
    check("R9 busy after start", 32'(busy), 32'd1);
    while (cnv && hi < 100) begin hi++; @(negedge clk); end
    check("R2 cnv width", hi, 1);
    while (cs_n && gap < 200) begin gap += (cnv ? 1000 : 1); @(negedge clk); end
    check("R3 wait gap", gap, 48);
    while (!done && to < 5000) begin to++; @(negedge clk); end
    check("R4 sclk rises", n_rise - r0, 8 * nb);
    msk = ~(64'hFFFF_FFFF_FFFF_FFFF >> (8 * db));
    check(rq, sample, w & msk[63:32]);
    check("R7 cm", {24'h0, cm}, hcm(m) ? ((w >> (8 * (3 - db))) & 32'hFF) : 32'h0);
    check("R7 cm_valid", 32'(cm_valid), 32'(hcm(m)));
    @(negedge clk);
    check("R8 done one cycle", 32'(done), 32'd0);
    check("R9 idle after done", 32'(busy), 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] prev;
    int to, c0;
    repeat (3) @(negedge clk);
    check("R1 cnv", 32'(cnv), 0);
    check("R1 cs_n", 32'(cs_n), 1);
    check("R1 sclk", 32'(sclk), 0);
    check("R1 busy/done", {busy, done}, 0);
    check("R1 outputs", sample | {cm, 23'h0, cm_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int l = 0; l < 4; l++)
      for (int m = 0; m < 8; m++) begin
        lane = 2'(l); mode = 3'(m); #1;
        check("R10 cfg byte", {24'h0, cfg}, (l << 6) | m);
      end

    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 4; p++)
        conv(m, (p == 0) ? 32'h80A5_C3FF : (p == 1) ? 32'h7F00_0180 :
                (32'h9E37_79B9 * (m * 4 + p + 1)) ^ (m << 5));

    // start while busy: second request during the wait is dropped
    c0 = n_cnv;
    mode = 3'd2; slv_word = 32'h1234_56AB; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    mode = 3'd4; start = 1'b1;
    @(negedge clk); start = 1'b0;
    to = 0;
    while (!done && to < 5000) begin to++; @(negedge clk); end
    check("R9 one cnv pulse", n_cnv - c0, 1);
    check("R9 latched mode kept", 32'(cm_valid), 1);
    check("R9 latched sample", sample, 32'h1234_5600);

    // start in the done cycle is ignored
    prev = sample;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R9 start at done ignored", {busy, cnv}, 0);
    @(negedge clk);
    check("R9 still idle", 32'(busy), 0);
    check("R8 hold", sample, prev);
    mode = 3'd3; slv_word = 32'hCAFE_0001; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R9 accepted from idle", 32'(busy), 1);
    to = 0;
    while (cs_n && to < 200) begin to++; @(negedge clk); end
    repeat (10) @(negedge clk);
    check("R8 hold during read", sample, prev);
    to = 0;
    while (!done && to < 5000) begin to++; @(negedge clk); end
    check("R6 avg word", sample, 32'hCAFE_0001);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule